// File: doc/BRIEF.md
# Configurable-Lane Hit Word Serializer

This block takes hit records from a core readout queue and sends them off chip over one, two, four or six serial lanes. Each record has four fields: an amplitude code, a logic-set number, a strip number and a time stamp. The block packs them into a 24-bit word, cuts the word into equal contiguous slices with one slice per active lane, and shifts every active lane in lockstep. Each lane moves two bits per readout-clock cycle, one per clock edge. With six lanes at a 70 MHz clock this gives 840 Mb/s in total.

Each lane is modelled as a pair of plain outputs per cycle. The early bit leaves during the first half of the cycle and the late bit during the second half, so a pad stage can merge them on both clock edges. The next record is fetched with a valid/ready handshake during the last cycle of the current word, so back-to-back words leave with no gap. When no record is offered at that point, an all-ones idle word goes out instead. The lane count is sampled only at word boundaries.

Top module: `hit_lane_serializer`

## Requirements
- R1: A word is packed as: b23..b20 marker 1010, b19..b12 time stamp, b11..b8 strip number, b7..b3 logic-set number, b2..b0 amplitude code.
- R2: With lane_mode = 0 (one lane), lane 0 sends the whole word from b23 down to b0 over 12 cycles.
- R3: With lane_mode = 1 (two lanes), lane 0 sends b11..b0 and lane 1 sends b23..b12, each MSB first, over 6 cycles.
- R4: With lane_mode = 2 (four lanes), lane k sends b(6k+5)..b(6k), MSB first, over 3 cycles.
- R5: With lane_mode = 3 (six lanes), lane k sends the nibble b(4k+3)..b(4k), MSB first, over 2 cycles.
- R6: In every cycle each active lane presents two consecutive slice bits. The early output carries the higher-numbered bit and the late output carries the next bit down.
- R7: Lanes that the current mode does not use drive 0 on both outputs.
- R8: frame_o is high exactly in the first cycle of each word.
- R9: in_ready is high exactly in the last cycle of each word. A record offered with in_valid in that cycle is sent starting in the next cycle, with no idle cycle between words.
- R10: When in_valid is low in a word's last cycle, the next word is the all-ones idle word.
- R11: lane_mode is sampled only in a word's last cycle. A change at any other time has no effect on the word in flight.
- R12: While rst_n is low, lane_mode is sampled and an idle word is loaded. The first cycle after reset is the first cycle of that idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_mode_i | input | 2 | Lane count select: 0=1, 1=2, 2=4, 3=6 lanes |
| in_valid | input | 1 | A hit record is offered |
| in_amp | input | 3 | Amplitude code |
| in_set | input | 5 | Logic-set number |
| in_strip | input | 4 | Strip number |
| in_stamp | input | 8 | Time stamp count |
| in_ready | output | 1 | Record is taken this cycle if in_valid is high |
| lane_early_o | output | 6 | First bit of each lane in this cycle |
| lane_late_o | output | 6 | Second bit of each lane in this cycle |
| frame_o | output | 1 | First cycle of a word |

## Verification
Each lane count is run with an unbroken stream of records. This separates the four slice layouts and word lengths, and shows whether words are joined with no gap. Streams with gaps and with no records at all exercise the idle fill. Records whose fields are all zeros or all ones catch swapped field positions and bit order. Phases that toggle lane_mode in the middle of a word, or change it at random, show whether the mode is held until the boundary. A reset in six-lane mode shows that the mode is sampled during reset.

// File: rtl/hls_pkg.sv
// Shared constants and helpers for the hit lane serializer.
// Assumes a 24-bit word that divides evenly into 1, 2, 4 or 6 slices,
// each slice an even number of bits.
package hls_pkg;
    localparam int WORD_W    = 24;
    localparam int AMP_W     = 3;
    localparam int SET_W     = 5;
    localparam int STRIP_W   = 4;
    localparam int STAMP_W   = 8;
    localparam int FIELD_W   = AMP_W + SET_W + STRIP_W + STAMP_W;
    localparam int MARK_W    = WORD_W - FIELD_W;
    localparam logic [MARK_W-1:0] MARKER = 4'b1010;
    localparam int MAX_LANES = 6;
    localparam int BEAT_BITS = 2;
    localparam int MAX_BEATS = WORD_W / BEAT_BITS;
    localparam int CNT_W     = $clog2(MAX_BEATS);
    localparam int MODE_W    = 2;
    localparam logic [WORD_W-1:0] IDLE_WORD = '1;

    typedef enum logic [MODE_W-1:0] {
        LM_ONE  = 2'd0,
        LM_TWO  = 2'd1,
        LM_FOUR = 2'd2,
        LM_SIX  = 2'd3
    } lane_mode_e;

    // Number of active lanes for a mode
    function automatic int lanes_of(input lane_mode_e m);
        case (m)
            LM_ONE:  return 1;
            LM_TWO:  return 2;
            LM_FOUR: return 4;
            default: return 6;
        endcase
    endfunction

    // Slice width per lane
    function automatic int slice_w(input lane_mode_e m);
        return WORD_W / lanes_of(m);
    endfunction

    // Cycles needed to send one word
    function automatic int beats_of(input lane_mode_e m);
        return slice_w(m) / BEAT_BITS;
    endfunction

    // One bit per lane that the mode uses
    function automatic logic [MAX_LANES-1:0] lane_mask(input lane_mode_e m);
        return MAX_LANES'((1 << lanes_of(m)) - 1);
    endfunction
endpackage

// File: rtl/hls_word_packer.sv
// Packs hit fields into one transmit word: marker on top, then time
// stamp, strip, set and amplitude down to bit 0. Purely combinational.
module hls_word_packer
    import hls_pkg::*;
(
    input  logic [AMP_W-1:0]   amp_i,
    input  logic [SET_W-1:0]   set_i,
    input  logic [STRIP_W-1:0] strip_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic [WORD_W-1:0]  word_o
);
    // Concatenate fields in fixed order
    always_comb begin
        word_o = {MARKER, stamp_i, strip_i, set_i, amp_i};
    end
endmodule

// File: rtl/hls_lane_slicer.sv
// Cuts a word into contiguous slices, lane 0 taking the lowest bits.
// Each slice is left-aligned so its MSB sits at the top of the lane
// register. Lanes beyond the mode's count receive zeros.
module hls_lane_slicer
    import hls_pkg::*;
(
    input  logic [WORD_W-1:0]                 word_i,
    input  lane_mode_e                        mode_i,
    output logic [MAX_LANES-1:0][WORD_W-1:0]  slices_o
);
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        int unsigned w;
        // Extract and left-align this lane's slice
        always_comb begin
            w = unsigned'(slice_w(mode_i));
            if (g < lanes_of(mode_i)) begin
                slices_o[g] = (word_i >> (g * w)) << (WORD_W - w);
            end else begin
                slices_o[g] = '0;
            end
        end
    end
endmodule

// File: rtl/hls_lane_shifter.sv
// One output lane: loads a left-aligned slice and moves BEAT bits per
// cycle toward the outputs. It has no reset of its own; the controller
// asserts load throughout reset.
module hls_lane_shifter #(
    parameter int W    = 24,
    parameter int BEAT = 2
) (
    input  logic         clk,
    input  logic         load_i,
    input  logic [W-1:0] slice_i,
    output logic         early_o,
    output logic         late_o
);
    logic [W-1:0] sr_q;

    // Load a new slice or advance by one beat
    always_ff @(posedge clk) begin
        if (load_i) begin
            sr_q <= slice_i;
        end else begin
            sr_q <= sr_q << BEAT;
        end
    end

    // Top two bits are the current beat
    always_comb begin
        early_o = sr_q[W-1];
        late_o  = sr_q[W-2];
    end
endmodule

// File: rtl/hls_beat_ctrl.sv
// Word timing: counts beats within a word, holds the lane mode for the
// whole word and raises ready in the last beat. Sampling the mode and
// loading happen on the same edge, so a new mode always starts with a
// fresh word. Synchronous active-low reset.
module hls_beat_ctrl
    import hls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lane_mode_e mode_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic       frame_o,
    output logic       load_o,
    output logic       take_o,
    output lane_mode_e next_mode_o,
    output lane_mode_e active_mode_o
);
    logic [CNT_W-1:0] cnt_q;
    lane_mode_e       mode_q;
    logic             last;

    // Detect the final beat of the current word
    always_comb begin
        last = (cnt_q == CNT_W'(beats_of(mode_q) - 1));
    end

    // Derive handshake and load controls
    always_comb begin
        ready_o       = rst_n && last;
        take_o        = rst_n && last && valid_i;
        load_o        = !rst_n || last;
        next_mode_o   = load_o ? mode_i : mode_q;
        frame_o       = (cnt_q == '0);
        active_mode_o = mode_q;
    end

    // Beat counter and mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
        end else if (last) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hit_lane_serializer.sv
// Top of the serializer: packs hit fields, picks data or idle, slices
// the word per lane mode and shifts all lanes in lockstep.
// Assumes the producer holds its record stable while in_valid is high.
module hit_lane_serializer
    import hls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    lane_mode_i,
    input  logic                 in_valid,
    input  logic [AMP_W-1:0]     in_amp,
    input  logic [SET_W-1:0]     in_set,
    input  logic [STRIP_W-1:0]   in_strip,
    input  logic [STAMP_W-1:0]   in_stamp,
    output logic                 in_ready,
    output logic [MAX_LANES-1:0] lane_early_o,
    output logic [MAX_LANES-1:0] lane_late_o,
    output logic                 frame_o
);
    logic [WORD_W-1:0]                packed_word;
    logic [WORD_W-1:0]                next_word;
    logic [MAX_LANES-1:0][WORD_W-1:0] slices;
    logic                             load;
    logic                             take;
    lane_mode_e                       next_mode;
    lane_mode_e                       active_mode;

    hls_word_packer u_pack (
        .amp_i   (in_amp),
        .set_i   (in_set),
        .strip_i (in_strip),
        .stamp_i (in_stamp),
        .word_o  (packed_word)
    );

    hls_beat_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (lane_mode_e'(lane_mode_i)),
        .valid_i       (in_valid),
        .ready_o       (in_ready),
        .frame_o       (frame_o),
        .load_o        (load),
        .take_o        (take),
        .next_mode_o   (next_mode),
        .active_mode_o (active_mode)
    );

    // Choose the accepted record or the idle fill
    always_comb begin
        next_word = take ? packed_word : IDLE_WORD;
    end

    hls_lane_slicer u_slice (
        .word_i   (next_word),
        .mode_i   (next_mode),
        .slices_o (slices)
    );

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_shift
        hls_lane_shifter #(
            .W    (WORD_W),
            .BEAT (BEAT_BITS)
        ) u_lane (
            .clk     (clk),
            .load_i  (load),
            .slice_i (slices[g]),
            .early_o (lane_early_o[g]),
            .late_o  (lane_late_o[g])
        );
    end
endmodule

// File: rtl/hls_serializer_chk.sv
// Protocol checks for the serializer, bound to every instance.
module hls_serializer_chk
    import hls_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 frame_o,
    input logic [MAX_LANES-1:0] lane_early_o,
    input logic [MAX_LANES-1:0] lane_late_o,
    input lane_mode_e           active_mode
);
    // R9
    ready_leads_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> frame_o);

    // R9
    ready_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R7
    unused_lanes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_early_o | lane_late_o) & ~lane_mask(active_mode)) == '0);

    // R10
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=>
        (((lane_early_o & lane_late_o) & lane_mask(active_mode)) == lane_mask(active_mode)));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_o |-> $stable(active_mode));
endmodule

bind hit_lane_serializer hls_serializer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .frame_o      (frame_o),
    .lane_early_o (lane_early_o),
    .lane_late_o  (lane_late_o),
    .active_mode  (active_mode)
);

// File: tb/hit_lane_serializer_test.sv
module hit_lane_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lane_mode = 2'd0;
    logic       valid = 1'b0;
    logic [2:0] amp = '0;
    logic [4:0] set_n = '0;
    logic [3:0] strip = '0;
    logic [7:0] stamp = '0;
    logic       ready;
    logic [5:0] early;
    logic [5:0] late;
    logic       frame;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    hit_lane_serializer uut (
        .clk(clk), .rst_n(rst_n), .lane_mode_i(lane_mode), .in_valid(valid),
        .in_amp(amp), .in_set(set_n), .in_strip(strip), .in_stamp(stamp),
        .in_ready(ready), .lane_early_o(early), .lane_late_o(late), .frame_o(frame)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int  m_beat = 0;
    int  m_mode = 0;
    int  m_word = 0;
    bit  accepted = 0;
    bit  fresh = 0;
    int  lcg = 12345;

    function automatic int n_lanes(input int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 4 : 6;
    endfunction

    function automatic int beats(input int m);
        return 12 / n_lanes(m);
    endfunction

    // R1 packing
    function automatic int pack_word();
        return (4'b1010 << 20) | (int'(stamp) << 12) | (int'(strip) << 8)
             | (int'(set_n) << 3) | int'(amp);
    endfunction

    always @(posedge clk) begin
        accepted = 0;
        if (!rst_n) begin
            m_beat = 0; m_mode = int'(lane_mode); m_word = 24'hFFFFFF; fresh = 1;
        end else if (m_beat == beats(m_mode) - 1) begin
            if (valid) begin m_word = pack_word(); accepted = 1; end
            else m_word = 24'hFFFFFF;
            m_mode = int'(lane_mode); m_beat = 0; fresh = 0;
        end else begin
            m_beat++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        string t;
        int sw;
        int nl;
        nl = n_lanes(m_mode);
        sw = 24 / nl;
        case (m_mode)
            0: t = "R2";
            1: t = "R3";
            2: t = "R4";
            default: t = "R5";
        endcase
        if (m_word == 24'hFFFFFF) t = {t, " R10"}; else t = {t, " R1"};
        if (fresh) t = {t, " R12"};
        if (int'(lane_mode) != m_mode) t = {t, " R11"};
        chk("R8 frame", int'(frame), int'(m_beat == 0));
        chk("R9 ready", int'(ready), int'(m_beat == beats(m_mode) - 1));
        for (int i = 0; i < 6; i++) begin
            if (i < nl) begin
                chk({t, " early"}, int'(early[i]), (m_word >> (i*sw + sw - 1 - 2*m_beat)) & 1);
                chk("R6 late", int'(late[i]), (m_word >> (i*sw + sw - 2 - 2*m_beat)) & 1);
            end else begin
                chk("R7 unused lane", int'({early[i], late[i]}), 0);
            end
        end
    endtask

    task automatic new_fields(input int kind);
        lcg = lcg * 1103515245 + 12345;
        if (kind == 1) begin amp = '0; set_n = '0; strip = '0; stamp = '0; end
        else if (kind == 2) begin amp = '1; set_n = '1; strip = '1; stamp = '1; end
        else begin
            amp = 3'(lcg >> 3); set_n = 5'(lcg >> 7); strip = 4'(lcg >> 13); stamp = 8'(lcg >> 17);
        end
    endtask

    // vmode: 0 always valid, 1 alternate, 2 random, 3 never; glitch toggles mode mid-word
    task automatic phase(input int mode, input int vmode, input int cycles,
                         input bit glitch, input bit rnd_mode, input int kind);
        lane_mode = 2'(mode);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (rst_n) compare();
            if (accepted || c == 0) new_fields(kind);
            case (vmode)
                0: valid = 1'b1;
                1: valid = (c % 4) < 2;
                2: valid = lcg[20];
                default: valid = 1'b0;
            endcase
            if (rnd_mode) lane_mode = 2'(lcg >> 24);
            if (glitch) begin
                if (m_beat == beats(m_mode) - 1) lane_mode = 2'(mode);
                else lane_mode = 2'(mode + 1 + (c % 3));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase(0, 0, 120, 0, 0, 0);
        phase(1, 0, 60, 0, 0, 0);
        phase(2, 0, 60, 0, 0, 0);
        phase(3, 0, 60, 0, 0, 0);
        phase(0, 1, 100, 0, 0, 0);
        phase(3, 2, 80, 0, 0, 0);
        phase(2, 3, 30, 0, 0, 0);
        phase(1, 0, 40, 0, 0, 1);
        phase(3, 0, 40, 0, 0, 2);
        phase(0, 0, 60, 1, 0, 2);
        phase(2, 2, 60, 1, 0, 0);
        phase(1, 2, 400, 0, 1, 0);
        @(negedge clk);
        rst_n = 1'b0; lane_mode = 2'd3;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        phase(3, 3, 6, 0, 0, 0);
        phase(3, 0, 40, 0, 0, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule